// File: doc/BRIEF.md
# Serial Timing Command Encoder

This block turns a handful of timing events into short framed codes on one serial line that moves in step with a reference clock. Three level inputs are watched for edges: a spill gate (rising and falling edges are both events), a counter-reset signal and a calibration signal (rising edges only). A host can also write a code into a fast-command port to issue an extra software timing command. Every event is mapped to its own code and sent as a fixed-length frame, one bit per reference clock, most significant bit first.

When the line is free, an event reaches the line after a fixed delay of 5.5 reference cycles. The half cycle comes from a final retiming flop that runs on the falling clock edge. Events that arrive while a frame is on the line are held as pending flags and sent in a fixed priority order. Frames follow one another with no idle bit between them. Between frames the line rests low, so a receiver finds the start of a frame by its leading pair of ones.

Top module: `tcmd_encoder`

## Requirements
- R1: After reset, and whenever nothing is pending, `ser_out` is low.
- R2: A frame is 9 bits, sent most significant bit first: a single 1, then the 8-bit code with bit 7 first. Legal codes have bit 7 and bit 0 set, so every frame begins with two ones and ends with a one.
- R3: A rising edge on `gate_in` sends code 0xB1, and a falling edge sends code 0xD1.
- R4: A rising edge on `cnt_rst_in` sends code 0xC5. Its falling edge sends nothing.
- R5: A rising edge on `calib_in` sends code 0x89. Its falling edge sends nothing.
- R6: A cycle with `fcmd_we` high sends a frame carrying `fcmd_code`, provided that code has bit 7 and bit 0 set. A write of any other code is dropped, and no frame follows it.
- R7: If the line is idle, an input change first sampled at rising edge 0 puts the first frame bit on `ser_out` at the falling edge between rising edges 5 and 6, which is 5.5 cycles later. The delay is the same for the fast-command path.
- R8: Events waiting at the same time are sent in this order: gate rising, gate falling, counter reset, calibration, fast command.
- R9: When another event is pending as a frame ends, the next frame starts on the very next bit, with no gap.
- R10: A repeat of an event that is already pending is merged into that one pending frame. For fast commands, the merged frame carries the most recently written code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one frame bit per period |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_in | input | 1 | Spill gate level; both edges are events |
| cnt_rst_in | input | 1 | Counter-reset level; rising edge is an event |
| calib_in | input | 1 | Calibration level; rising edge is an event |
| fcmd_we | input | 1 | Fast-command write strobe, one cycle per command |
| fcmd_code | input | CODE_W | Code to send for a fast command |
| ser_out | output | 1 | Serial frame line, updated on the falling clock edge |

## Verification
The assertions assume that the level inputs are low while reset is asserted, so that no edge is seen at reset release. They also assume that the code table holds only legal codes. The bench changes every input on the falling clock edge and brings each level input back low after each test. The stimulus exercises isolated events, which check the exact delay, and pile-ups of simultaneous and overlapping events, which check the priority order, back-to-back frames and merging. Illegal fast-command codes and falling edges with no code are checked by watching the line stay quiet.

// File: rtl/tce_pkg.sv
package tce_pkg;

   localparam int unsigned TCE_CODE_W = 8;

   // default code table
   localparam logic [TCE_CODE_W-1:0] TCE_GATE_RISE = 8'hB1;
   localparam logic [TCE_CODE_W-1:0] TCE_GATE_FALL = 8'hD1;
   localparam logic [TCE_CODE_W-1:0] TCE_CNT_RISE  = 8'hC5;
   localparam logic [TCE_CODE_W-1:0] TCE_CAL_RISE  = 8'h89;

   // event slots; the index is the priority (0 = highest)
   typedef enum int unsigned {
      EV_GATE_RISE = 0,
      EV_GATE_FALL = 1,
      EV_CNT_RISE  = 2,
      EV_CAL_RISE  = 3,
      EV_FCMD      = 4
   } tce_event_e;

   localparam int unsigned TCE_N_EV = 5;

endpackage

// File: rtl/tce_edge_det.sv
module tce_edge_det #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          DETECT_FALL = 1'b0,
   localparam int unsigned N_OUT      = DETECT_FALL ? 2 : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl_i,
   output logic [N_OUT-1:0] pulse_o   // [0] rise, [1] fall when enabled
);

   logic [SYNC_STAGES:0] sync_q;
   logic [N_OUT-1:0]     pulse_q;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tce_edge_det: SYNC_STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-1:0], lvl_i};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q[0] <= 1'b0;
      else        pulse_q[0] <= sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
   end

   if (DETECT_FALL) begin : g_fall
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pulse_q[N_OUT-1] <= 1'b0;
         else        pulse_q[N_OUT-1] <= ~sync_q[SYNC_STAGES-1] & sync_q[SYNC_STAGES];
      end
   end

   assign pulse_o = pulse_q;

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q[0] |=> !pulse_q[0]); // R7

endmodule

// File: rtl/tce_cmd_pipe.sv
module tce_cmd_pipe #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CODE_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              pulse_o,
   output logic [CODE_W-1:0] code_o
);

   logic [SYNC_STAGES:0]             vld_q;
   logic [SYNC_STAGES:0][CODE_W-1:0] cod_q;

   for (genvar s = 0; s <= SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q[0] <= 1'b0;
               cod_q[0] <= '0;
            end else begin
               vld_q[0] <= we_i;
               cod_q[0] <= code_i;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q[s] <= 1'b0;
               cod_q[s] <= '0;
            end else begin
               vld_q[s] <= vld_q[s-1];
               cod_q[s] <= cod_q[s-1];
            end
         end
      end
   end

   // only codes with both framing bits set may become frames
   assign pulse_o = vld_q[SYNC_STAGES] & cod_q[SYNC_STAGES][CODE_W-1] & cod_q[SYNC_STAGES][0];
   assign code_o  = cod_q[SYNC_STAGES];

endmodule

// File: rtl/tce_arbiter.sv
module tce_arbiter #(
   parameter int unsigned N_EV   = 5,
   parameter int unsigned CODE_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_EV-1:0]             ev_pulse_i,
   input  logic [N_EV-1:0][CODE_W-1:0] code_tab_i,
   input  logic                        take_i,
   output logic                        req_valid_o,
   output logic [CODE_W-1:0]           req_code_o
);

   logic [N_EV-1:0] pend_q;
   logic [N_EV-1:0] ahead;
   logic [N_EV-1:0] pick;
   logic [N_EV-1:0] grant;

   for (genvar i = 0; i < N_EV; i++) begin : g_prio
      if (i == 0) begin : g_top
         assign ahead[i] = 1'b0;
      end else begin : g_rest
         assign ahead[i] = ahead[i-1] | pend_q[i-1];
      end
      assign pick[i]  = pend_q[i] & ~ahead[i];
      assign grant[i] = pick[i] & take_i;

      AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_q[i] && !take_i) |=> pend_q[i]); // R8
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~grant) | ev_pulse_i;
   end

   always_comb begin
      req_code_o = '0;
      for (int i = 0; i < N_EV; i++) begin
         if (pick[i]) req_code_o = req_code_o | code_tab_i[i];
      end
   end

   assign req_valid_o = |pend_q;

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R8

endmodule

// File: rtl/tce_serializer.sv
module tce_serializer #(
   parameter int unsigned CODE_W = 8,
   localparam int unsigned FRAME_W = CODE_W + 1,
   localparam int unsigned CNT_W   = $clog2(FRAME_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic [CODE_W-1:0] req_code_i,
   output logic              take_o,
   output logic              ser_o
);

   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

   logic [FRAME_W-1:0] shreg_q;
   logic [CNT_W-1:0]   bitcnt_q;
   logic               busy_q;
   logic               line_p;
   logic               line_n;

   // free while idle or on the last bit of the current frame
   assign take_o = !busy_q || (bitcnt_q == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q  <= '0;
         bitcnt_q <= '0;
         busy_q   <= 1'b0;
      end else if (take_o) begin
         if (req_valid_i) begin
            shreg_q  <= {1'b1, req_code_i};
            bitcnt_q <= '0;
            busy_q   <= 1'b1;
         end else begin
            bitcnt_q <= '0;
            busy_q   <= 1'b0;
         end
      end else begin
         shreg_q  <= {shreg_q[FRAME_W-2:0], 1'b0};
         bitcnt_q <= bitcnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_p <= 1'b0;
      else        line_p <= busy_q & shreg_q[FRAME_W-1];
   end

   // half-cycle retime on the opposite edge
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) line_n <= 1'b0;
      else        line_n <= line_p;
   end

   assign ser_o = line_n;

   AST_START_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && bitcnt_q < CNT_W'(2)) |=> line_p); // R2
   AST_STOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && bitcnt_q == LAST_BIT) |=> line_p); // R2
   AST_LEGAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && req_valid_i) |-> (req_code_i[CODE_W-1] && req_code_i[0])); // R6

endmodule

// File: rtl/tcmd_encoder.sv
module tcmd_encoder
   import tce_pkg::*;
#(
   parameter int unsigned       CODE_W         = TCE_CODE_W,
   parameter int unsigned       SYNC_STAGES    = 2,
   parameter logic [CODE_W-1:0] GATE_RISE_CODE = CODE_W'(TCE_GATE_RISE),
   parameter logic [CODE_W-1:0] GATE_FALL_CODE = CODE_W'(TCE_GATE_FALL),
   parameter logic [CODE_W-1:0] CNT_RISE_CODE  = CODE_W'(TCE_CNT_RISE),
   parameter logic [CODE_W-1:0] CAL_RISE_CODE  = CODE_W'(TCE_CAL_RISE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_in,
   input  logic              cnt_rst_in,
   input  logic              calib_in,
   input  logic              fcmd_we,
   input  logic [CODE_W-1:0] fcmd_code,
   output logic              ser_out
);

   localparam int unsigned N_EV = TCE_N_EV;

   function automatic bit code_ok(logic [CODE_W-1:0] c);
      return c[CODE_W-1] && c[0];
   endfunction

   localparam bit TABLE_OK = code_ok(GATE_RISE_CODE) && code_ok(GATE_FALL_CODE) &&
                             code_ok(CNT_RISE_CODE)  && code_ok(CAL_RISE_CODE);

   if (CODE_W < 3) begin : g_bad_width
      $error("tcmd_encoder: CODE_W must be at least 3");
   end
   if (!TABLE_OK) begin : g_bad_table
      $error("tcmd_encoder: every table code needs its top and bottom bits set");
   end

   logic [1:0]                  gate_ev;
   logic [0:0]                  cnt_ev;
   logic [0:0]                  cal_ev;
   logic                        cmd_pulse;
   logic [CODE_W-1:0]           cmd_code;
   logic [CODE_W-1:0]           fcmd_q;
   logic [N_EV-1:0]             ev_pulse;
   logic [N_EV-1:0][CODE_W-1:0] code_tab;
   logic                        take;
   logic                        req_valid;
   logic [CODE_W-1:0]           req_code;

   tce_edge_det #(.SYNC_STAGES(SYNC_STAGES), .DETECT_FALL(1'b1)) u_gate (
      .clk(clk), .rst_n(rst_n), .lvl_i(gate_in), .pulse_o(gate_ev));

   tce_edge_det #(.SYNC_STAGES(SYNC_STAGES), .DETECT_FALL(1'b0)) u_cnt (
      .clk(clk), .rst_n(rst_n), .lvl_i(cnt_rst_in), .pulse_o(cnt_ev));

   tce_edge_det #(.SYNC_STAGES(SYNC_STAGES), .DETECT_FALL(1'b0)) u_cal (
      .clk(clk), .rst_n(rst_n), .lvl_i(calib_in), .pulse_o(cal_ev));

   tce_cmd_pipe #(.SYNC_STAGES(SYNC_STAGES), .CODE_W(CODE_W)) u_cmd (
      .clk(clk), .rst_n(rst_n), .we_i(fcmd_we), .code_i(fcmd_code),
      .pulse_o(cmd_pulse), .code_o(cmd_code));

   // latest legal fast-command code wins while its slot is pending
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         fcmd_q <= '0;
      else if (cmd_pulse) fcmd_q <= cmd_code;
   end

   assign ev_pulse[EV_GATE_RISE] = gate_ev[0];
   assign ev_pulse[EV_GATE_FALL] = gate_ev[1];
   assign ev_pulse[EV_CNT_RISE]  = cnt_ev[0];
   assign ev_pulse[EV_CAL_RISE]  = cal_ev[0];
   assign ev_pulse[EV_FCMD]      = cmd_pulse;

   assign code_tab[EV_GATE_RISE] = GATE_RISE_CODE;
   assign code_tab[EV_GATE_FALL] = GATE_FALL_CODE;
   assign code_tab[EV_CNT_RISE]  = CNT_RISE_CODE;
   assign code_tab[EV_CAL_RISE]  = CAL_RISE_CODE;
   assign code_tab[EV_FCMD]      = fcmd_q;

   tce_arbiter #(.N_EV(N_EV), .CODE_W(CODE_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .ev_pulse_i(ev_pulse), .code_tab_i(code_tab),
      .take_i(take), .req_valid_o(req_valid), .req_code_o(req_code));

   tce_serializer #(.CODE_W(CODE_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_code_i(req_code),
      .take_o(take), .ser_o(ser_out));

endmodule

// File: tb/tcmd_encoder_tb_top.sv
module tcmd_encoder_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       gate_in = 1'b0;
   logic       cnt_rst_in = 1'b0;
   logic       calib_in = 1'b0;
   logic       fcmd_we = 1'b0;
   logic [7:0] fcmd_code = 8'h00;
   logic       ser_out;

   always #2.5 clk = ~clk;   // 200 MHz

   tcmd_encoder dut_i (
      .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .cnt_rst_in(cnt_rst_in),
      .calib_in(calib_in), .fcmd_we(fcmd_we), .fcmd_code(fcmd_code), .ser_out(ser_out));

   int    cyc = 0;
   int    checks = 0;
   int    fails = 0;
   int    frames = 0;
   bit    done = 1'b0;
   bit    in_frame = 1'b0;
   int    f_start = 0;
   int    f_bits = 0;
   logic [7:0] f_code = 8'h00;

   int    exp_code_q[$];
   int    exp_start_q[$];
   string exp_tag_q[$];

   task automatic expect_frame(input int code, input int start, input string tag);
      exp_code_q.push_back(code);
      exp_start_q.push_back(start);
      exp_tag_q.push_back(tag);
   endtask

   // monitor: ser_out moves on the falling edge, sampled on the rising edge
   always @(posedge clk) begin
      cyc++;
      if (rst_n && !done) begin
         if (!in_frame) begin
            if (ser_out === 1'b1) begin
               in_frame = 1'b1;
               f_start  = cyc;
               f_bits   = 1;
               f_code   = 8'h00;
            end
         end else begin
            f_code = {f_code[6:0], ser_out};
            f_bits++;
            if (f_bits == 9) begin
               in_frame = 1'b0;
               frames++;
               checks++;
               if (exp_code_q.size() == 0) begin
                  fails++;
                  $display("FAIL R1: unexpected frame code 0x%02h at cycle %0d, expected no frame", f_code, f_start);
               end else begin
                  automatic int    ec = exp_code_q.pop_front();
                  automatic int    es = exp_start_q.pop_front();
                  automatic string et = exp_tag_q.pop_front();
                  if (f_code !== ec[7:0] || (es >= 0 && f_start != es)) begin
                     fails++;
                     $display("FAIL %s: got code 0x%02h start %0d, expected code 0x%02h start %0d",
                              et, f_code, f_start, ec[7:0], es);
                  end
               end
            end
         end
      end
   end

   task automatic drain(input string tag);
      int t = 0;
      while ((exp_code_q.size() != 0 || in_frame) && t < 500) begin
         @(negedge clk);
         t++;
      end
      if (exp_code_q.size() != 0) begin
         checks++;
         fails++;
         $display("FAIL %s: %0d frames missing, expected 0", tag, exp_code_q.size());
         exp_code_q.delete();
         exp_start_q.delete();
         exp_tag_q.delete();
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic quiet(input int n, input string tag);
      int f0 = frames;
      repeat (n) @(negedge clk);
      checks++;
      if (frames != f0 || in_frame || ser_out !== 1'b0) begin
         fails++;
         $display("FAIL %s: line active (frames %0d, line %b), expected 0 frames and line 0",
                  tag, frames - f0, ser_out);
      end
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: run not finished, expected completion");
         report();
      end
   end

   // sender: inputs change on the falling edge at cycle k; the first sampled bit lands at k+7 (R7)
   initial begin
      int k;
      repeat (4) @(negedge clk);
      checks++;
      if (ser_out !== 1'b0) begin
         fails++;
         $display("FAIL R1: line %b during reset, expected 0", ser_out);
      end
      rst_n = 1'b1;
      quiet(10, "R1");

      // isolated gate edges
      k = cyc; gate_in = 1'b1; expect_frame(8'hB1, k + 7, "R3/R7 gate rise");
      drain("R3");
      k = cyc; gate_in = 1'b0; expect_frame(8'hD1, k + 7, "R3/R7 gate fall");
      drain("R3");

      // counter reset: rise only
      k = cyc; cnt_rst_in = 1'b1; expect_frame(8'hC5, k + 7, "R4 cnt rise");
      drain("R4");
      cnt_rst_in = 1'b0;
      quiet(25, "R4 falling edge ignored");

      // calibration: rise only
      k = cyc; calib_in = 1'b1; expect_frame(8'h89, k + 7, "R5 cal rise");
      drain("R5");
      calib_in = 1'b0;
      quiet(25, "R5 falling edge ignored");

      // fast command, legal code, same delay
      k = cyc; fcmd_we = 1'b1; fcmd_code = 8'hA5; expect_frame(8'hA5, k + 7, "R6/R7 fcmd");
      @(negedge clk); fcmd_we = 1'b0;
      drain("R6");

      // illegal codes: bit 7 clear, then bit 0 clear
      fcmd_we = 1'b1; fcmd_code = 8'h41;
      @(negedge clk); fcmd_code = 8'h80;
      @(negedge clk); fcmd_we = 1'b0;
      quiet(25, "R6 illegal code dropped");

      // all at once: priority order, back to back
      k = cyc;
      gate_in = 1'b1; cnt_rst_in = 1'b1; calib_in = 1'b1;
      fcmd_we = 1'b1; fcmd_code = 8'h93;
      expect_frame(8'hB1, k + 7,  "R8 first gate");
      expect_frame(8'hC5, k + 16, "R8/R9 second cnt");
      expect_frame(8'h89, k + 25, "R8/R9 third cal");
      expect_frame(8'h93, k + 34, "R8/R9 fourth fcmd");
      @(negedge clk); fcmd_we = 1'b0;
      drain("R8");

      // gate fall with fast command together
      k = cyc;
      gate_in = 1'b0; cnt_rst_in = 1'b0; calib_in = 1'b0;
      fcmd_we = 1'b1; fcmd_code = 8'hA5;
      expect_frame(8'hD1, k + 7,  "R8 gate fall first");
      expect_frame(8'hA5, k + 16, "R8/R9 fcmd after fall");
      @(negedge clk); fcmd_we = 1'b0;
      drain("R8");

      // event arriving mid-frame is queued
      k = cyc; gate_in = 1'b1; expect_frame(8'hB1, k + 7, "R7 gate rise");
      repeat (3) @(negedge clk);
      calib_in = 1'b1; expect_frame(8'h89, k + 16, "R9 queued cal");
      drain("R9");
      calib_in = 1'b0;
      quiet(10, "R5 fall quiet");

      // two fast commands while waiting merge into the last code
      k = cyc; gate_in = 1'b0; expect_frame(8'hD1, k + 7, "R3 gate fall");
      @(negedge clk); fcmd_we = 1'b1; fcmd_code = 8'hA5;
      @(negedge clk); fcmd_code = 8'h99;
      @(negedge clk); fcmd_we = 1'b0;
      expect_frame(8'h99, k + 16, "R10 merged fcmd");
      drain("R10");
      quiet(20, "R10 no second fcmd frame");

      // lower priority arrives first but waits behind higher priority
      k = cyc; gate_in = 1'b1; expect_frame(8'hB1, k + 7, "R7 gate rise");
      @(negedge clk); calib_in = 1'b1;
      @(negedge clk); cnt_rst_in = 1'b1;
      expect_frame(8'hC5, k + 16, "R8 cnt before cal");
      expect_frame(8'h89, k + 25, "R8/R9 cal last");
      drain("R8");
      cnt_rst_in = 1'b0; calib_in = 1'b0;
      k = cyc; gate_in = 1'b0; expect_frame(8'hD1, k + 7, "R3 gate fall");
      drain("R3");
      quiet(15, "R1 idle low");

      done = 1'b1;
      report();
   end

endmodule